// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit resolves the operand of an accumulator-style instruction. It takes a 4-bit mode code, the instruction's address field, the value of the selected register, the program counter and the stack pointer. From these it works out the final effective address (EA) and fetches the operand. It reads one word at a time through a synchronous memory port. Depending on the mode it makes zero, one or two reads, and a second read can depend on the data the first read returned.

A caller raises `start` for one cycle while the unit is idle. The unit samples every input on that edge. It then runs its reads, drives `busy` while reads are outstanding, and pulses `done`. The values `ea_out`, `operand` and `illegal` appear with `done` and hold until the next `done`. All address arithmetic wraps modulo 2^W.

Top module: `ea_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `mem_rd_en` and `illegal` are 0, and `ea_out` and `operand` are 0.
- R2: Mode 0 (immediate) makes no memory read. `done` rises one cycle after the start cycle with `operand` = `ea_out` = the address field.
- R3: Mode 3 (register) makes no memory read. `done` rises one cycle after start with `operand` = `reg_val` and `ea_out` = the address field.
- R4: Mode 1 (direct) reads once at A, and mode 9 (stack top) reads once at `sp`. In both, `ea_out` is the address that was read and `operand` is the word returned.
- R5: Mode 4 (register indirect) reads once at R. Mode 5 (displacement) reads once at A+R. Mode 6 (PC-relative) reads once at A+PC. In each, `ea_out` is the address read and `operand` is the word returned.
- R6: Mode 2 (indirect) first reads at A. It then reads at the returned word, which becomes `ea_out`. The second word is `operand`.
- R7: Mode 7 (preindexed indirect) first reads at A+R. It then reads at the returned word, which becomes `ea_out`. The second word is `operand`.
- R8: Mode 8 (postindexed indirect) first reads at A. The returned word plus R becomes `ea_out`. The unit reads there, and that word is `operand`.
- R9: Every address sum wraps modulo 2^W.
- R10: Mode codes 10 to 15 make no read. `done` rises one cycle after start with `illegal` = 1 and `ea_out` = `operand` = 0. Legal modes return `illegal` = 0.
- R11: Each read is a one-cycle `mem_rd_en` pulse, and its data is taken one cycle later. With n reads, `mem_rd_en` is high in cycles 1 and 3 after start, `busy` is high in cycles 1 to 2n, and `done` is high in cycle 2n+1 only.
- R12: A `start` raised while `busy` is high is ignored. It changes neither the read sequence nor the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address resolution (taken when not busy) |
| mode | input | 4 | Addressing mode code |
| addr_field | input | W | Address field A of the instruction |
| reg_val | input | W | Contents of the selected register R |
| pc | input | W | Program counter |
| sp | input | W | Stack pointer |
| mem_rd_en | output | 1 | Memory read request, one cycle per read |
| mem_addr | output | W | Memory read address |
| mem_rd_data | input | W | Read data, valid the cycle after the request |
| busy | output | 1 | Reads in progress, start ignored |
| done | output | 1 | One-cycle result strobe |
| ea_out | output | W | Resolved effective address |
| operand | output | W | Resolved operand |
| illegal | output | 1 | Mode code was not a defined mode |

## Verification
Let the start cycle be cycle 0. A mode that needs n reads raises its read requests in cycles 1 and 3. Each returned word is taken one cycle after its request, and the results arrive with `done` in cycle 2n+1. The bench's reference model derives n and the expected addresses and words for each mode from its own memory function. On every falling edge it compares `busy`, `done` and `mem_rd_en` against the expected cycle pattern. It also compares `mem_addr` in the request cycles and the three results in the `done` cycle. Because sampling happens on the falling edge, every registered output has settled by the time it is read.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    M_IMM  = 4'd0,
    M_DIR  = 4'd1,
    M_IND  = 4'd2,
    M_REG  = 4'd3,
    M_RIND = 4'd4,
    M_DISP = 4'd5,
    M_REL  = 4'd6,
    M_PRE  = 4'd7,
    M_POST = 4'd8,
    M_STK  = 4'd9
  } mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_CAP  = 2'd2
  } state_e;
endpackage

// File: rtl/ea_wrap_add.sv
module ea_wrap_add #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s
);
  // carry out is dropped: sums wrap modulo 2^W
  assign s = a + b;
endmodule

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   mode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] r,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] sp,
  output logic         legal,
  output logic [1:0]   nreads,
  output logic [W-1:0] first_addr,
  output logic [W-1:0] second_off,
  output logic [W-1:0] zero_op
);
  logic [W-1:0] base;
  logic [W-1:0] indexed;

  assign base = (mode == M_REL) ? pc : r;

  ea_wrap_add #(.W(W)) u_index_add (.a(a), .b(base), .s(indexed));

  assign legal      = (mode <= M_STK);
  assign second_off = (mode == M_POST) ? r : '0;
  assign zero_op    = (mode == M_IMM) ? a : r;

  always_comb begin
    nreads     = 2'd0;
    first_addr = a;
    case (mode)
      M_DIR:  begin nreads = 2'd1; first_addr = a;       end
      M_IND:  begin nreads = 2'd2; first_addr = a;       end
      M_RIND: begin nreads = 2'd1; first_addr = r;       end
      M_DISP: begin nreads = 2'd1; first_addr = indexed; end
      M_REL:  begin nreads = 2'd1; first_addr = indexed; end
      M_PRE:  begin nreads = 2'd2; first_addr = indexed; end
      M_POST: begin nreads = 2'd2; first_addr = a;       end
      M_STK:  begin nreads = 2'd1; first_addr = sp;      end
      default: begin nreads = 2'd0; first_addr = a;      end
    endcase
  end
endmodule

// File: rtl/ea_read_seq.sv
module ea_read_seq
  import ea_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         legal,
  input  logic [1:0]   nreads,
  input  logic [W-1:0] first_addr,
  input  logic [W-1:0] second_off,
  input  logic [W-1:0] zero_op,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] mem_rd_data,
  output logic         mem_rd_en,
  output logic [W-1:0] mem_addr,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] ea_out,
  output logic [W-1:0] operand,
  output logic         illegal
);
  state_e       state;
  logic         two_q;
  logic         phase;
  logic [W-1:0] off_q;
  logic [W-1:0] next_addr;

  ea_wrap_add #(.W(W)) u_post_add (.a(mem_rd_data), .b(off_q), .s(next_addr));

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
      done      <= 1'b0;
      ea_out    <= '0;
      operand   <= '0;
      illegal   <= 1'b0;
      two_q     <= 1'b0;
      phase     <= 1'b0;
      off_q     <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      done      <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            if (!legal) begin
              done    <= 1'b1;
              illegal <= 1'b1;
              ea_out  <= '0;
              operand <= '0;
            end else if (nreads == 2'd0) begin
              done    <= 1'b1;
              illegal <= 1'b0;
              ea_out  <= a_in;
              operand <= zero_op;
            end else begin
              mem_rd_en <= 1'b1;
              mem_addr  <= first_addr;
              two_q     <= (nreads == 2'd2);
              off_q     <= second_off;
              phase     <= 1'b0;
              state     <= S_WAIT;
            end
          end
        end
        S_WAIT: state <= S_CAP;
        S_CAP: begin
          if (two_q && !phase) begin
            mem_rd_en <= 1'b1;
            mem_addr  <= next_addr;
            phase     <= 1'b1;
            state     <= S_WAIT;
          end else begin
            done    <= 1'b1;
            illegal <= 1'b0;
            ea_out  <= mem_addr;
            operand <= mem_rd_data;
            state   <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: a request lasts one cycle and the unit stays busy behind it
  assert_read_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en && busy);

  // R11: done never coincides with an outstanding request
  assert_done_no_read_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_rd_en && !busy);

  // R10: undefined modes finish at once without touching memory
  assert_illegal_noread_R10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !legal) |=> done && illegal && !mem_rd_en);

  // R12: a start while busy never launches a fresh first read
  assert_busy_ignores_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && start && state == S_WAIT) |=> !mem_rd_en);
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [3:0]   mode,
  input  logic [W-1:0] addr_field,
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] sp,
  output logic         mem_rd_en,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rd_data,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] ea_out,
  output logic [W-1:0] operand,
  output logic         illegal
);
  logic         legal;
  logic [1:0]   nreads;
  logic [W-1:0] first_addr;
  logic [W-1:0] second_off;
  logic [W-1:0] zero_op;

  ea_mode_decode #(.W(W)) u_decode (
    .mode(mode), .a(addr_field), .r(reg_val), .pc(pc), .sp(sp),
    .legal(legal), .nreads(nreads), .first_addr(first_addr),
    .second_off(second_off), .zero_op(zero_op)
  );

  ea_read_seq #(.W(W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .legal(legal), .nreads(nreads),
    .first_addr(first_addr), .second_off(second_off), .zero_op(zero_op),
    .a_in(addr_field), .mem_rd_data(mem_rd_data), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .busy(busy), .done(done), .ea_out(ea_out),
    .operand(operand), .illegal(illegal)
  );

  // R2: immediate resolves next cycle to the address field, no read
  assert_imm_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode == M_IMM) |=>
      done && !mem_rd_en && operand == $past(addr_field) && ea_out == $past(addr_field));

  // R3: register mode resolves next cycle to the register value, no read
  assert_reg_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && mode == M_REG) |=>
      done && !mem_rd_en && operand == $past(reg_val));
endmodule

// File: tb/test_ea_unit.sv
module test_ea_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [3:0]   mode = '0;
  logic [W-1:0] addr_field = '0;
  logic [W-1:0] reg_val = '0;
  logic [W-1:0] pc = '0;
  logic [W-1:0] sp = '0;
  logic         mem_rd_en;
  logic [W-1:0] mem_addr;
  logic [W-1:0] mem_rd_data = '0;
  logic         busy;
  logic         done;
  logic [W-1:0] ea_out;
  logic [W-1:0] operand;
  logic         illegal;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  ea_unit #(.W(W)) i_ea_unit (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .addr_field(addr_field),
    .reg_val(reg_val), .pc(pc), .sp(sp), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .busy(busy), .done(done),
    .ea_out(ea_out), .operand(operand), .illegal(illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory contents are a fixed scramble of the address
  function automatic logic [W-1:0] memf(input logic [W-1:0] x);
    return {x[6:0], x[15:7]} ^ 16'hC3A5;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= memf(mem_addr);

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one resolution and compare every cycle until done
  task automatic run_op(input string req, input logic [3:0] m,
                        input logic [W-1:0] a, input logic [W-1:0] r,
                        input logic [W-1:0] p, input logic [W-1:0] s,
                        input bit extra);
    int n;
    logic [W-1:0] ad [2];
    logic [W-1:0] e_ea, e_op;
    logic e_ill;
    e_ill = 1'b0; n = 0; ad[0] = '0; ad[1] = '0;
    case (m)
      4'd0: begin e_ea = a; e_op = a; end
      4'd3: begin e_ea = a; e_op = r; end
      4'd1: begin n = 1; ad[0] = a; end
      4'd9: begin n = 1; ad[0] = s; end
      4'd4: begin n = 1; ad[0] = r; end
      4'd5: begin n = 1; ad[0] = a + r; end
      4'd6: begin n = 1; ad[0] = a + p; end
      4'd2: begin n = 2; ad[0] = a; ad[1] = memf(a); end
      4'd7: begin n = 2; ad[0] = a + r; ad[1] = memf(ad[0]); end
      4'd8: begin n = 2; ad[0] = a; ad[1] = memf(a) + r; end
      default: begin e_ill = 1'b1; e_ea = '0; e_op = '0; end
    endcase
    if (n > 0) begin e_ea = ad[n-1]; e_op = memf(e_ea); end

    @(negedge clk);
    start = 1'b1; mode = m; addr_field = a; reg_val = r; pc = p; sp = s;
    for (int k = 1; k <= 2*n + 1; k++) begin
      @(negedge clk);
      start = extra && (k <= 2*n);
      if (start) begin mode = 4'd0; addr_field = 16'hFFFF; end
      chk(req, "busy", {15'd0, busy}, {15'd0, k <= 2*n});
      chk(req, "done", {15'd0, done}, {15'd0, k == 2*n + 1});
      chk(req, "mem_rd_en", {15'd0, mem_rd_en}, {15'd0, (k % 2 == 1) && (k < 2*n + 1)});
      if ((k % 2 == 1) && (k < 2*n + 1)) chk(req, "mem_addr", mem_addr, ad[k/2]);
      if (k == 2*n + 1) begin
        chk(req, "ea_out", ea_out, e_ea);
        chk(req, "operand", operand, e_op);
        chk(req, "illegal", {15'd0, illegal}, {15'd0, e_ill});
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(req, "idle done", {15'd0, done}, 16'd0);
    chk(req, "idle busy", {15'd0, busy}, 16'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        mismatched++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy", {15'd0, busy}, 16'd0);
    chk("R1", "done", {15'd0, done}, 16'd0);
    chk("R1", "mem_rd_en", {15'd0, mem_rd_en}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ea_out", ea_out, 16'd0);
    chk("R1", "operand", operand, 16'd0);
    chk("R1", "illegal", {15'd0, illegal}, 16'd0);

    run_op("R2",  4'd0, 16'h1234, 16'h0, 16'h0, 16'h0, 1'b0);
    run_op("R3",  4'd3, 16'h0005, 16'hBEEF, 16'h0, 16'h0, 1'b0);
    run_op("R4",  4'd1, 16'h0100, 16'h0, 16'h0, 16'h0, 1'b0);
    run_op("R4",  4'd9, 16'h0, 16'h0, 16'h0, 16'hFFF0, 1'b0);
    run_op("R5",  4'd4, 16'h0, 16'h2222, 16'h0, 16'h0, 1'b0);
    run_op("R5",  4'd5, 16'h0040, 16'h0020, 16'h0, 16'h0, 1'b0);
    run_op("R5",  4'd6, 16'h0010, 16'h0, 16'h3000, 16'h0, 1'b0);
    run_op("R9",  4'd5, 16'hFFF0, 16'h0020, 16'h0, 16'h0, 1'b0);
    run_op("R9",  4'd6, 16'h0008, 16'h0, 16'hFFFC, 16'h0, 1'b0);
    run_op("R6",  4'd2, 16'h0300, 16'h0, 16'h0, 16'h0, 1'b0);
    run_op("R7",  4'd7, 16'h0100, 16'h0011, 16'h0, 16'h0, 1'b0);
    run_op("R8",  4'd8, 16'h0400, 16'hF000, 16'h0, 16'h0, 1'b0);
    run_op("R10", 4'd10, 16'h0400, 16'h0, 16'h0, 16'h0, 1'b0);
    run_op("R10", 4'd15, 16'hABCD, 16'h0, 16'h0, 16'h0, 1'b0);
    run_op("R11", 4'd1, 16'h7777, 16'h0, 16'h0, 16'h0, 1'b0);
    run_op("R12", 4'd2, 16'h0555, 16'h0, 16'h0, 16'h0, 1'b1);
    run_op("R12", 4'd8, 16'h0666, 16'h1111, 16'h0, 16'h0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule